// File: doc/BRIEF.md
# Unified memory port arbiter

This block shares one single-port memory between the fetch stage and the data-access stage of a five-stage in-order pipeline. There is no separate instruction store: program words and load/store data live in the same array. In each cycle the block looks at a fetch request from the front end and a load or store request from the data stage, and gives the memory port to one of them.

The rule is fixed. A data access always gets the port, and a fetch that collides with one is deferred. The older instruction in the data stage is therefore never held back by a younger fetch, which guarantees forward progress. While a fetch is deferred, the block raises a stall output. The front end uses it to hold its program counter and to place a bubble word into the fetch/decode register. The front end presents the same fetch again on the next cycle, and it is served as soon as no data access competes with it.

Stores write the memory in the cycle they are granted. The memory has a one-cycle read latency. Load data and fetched instruction words come back on the cycle after the grant, each on its own return path with its own valid flag.

Top module: `umem_arbiter`

## Requirements
- R1: A data request (`dm_req`=1) drives the memory port in the same cycle, whether or not a fetch is pending: `mem_en`=1, `mem_addr`=`dm_addr`, `mem_we`=`dm_we`.
- R2: When `if_req`=1 and `dm_req`=0, the port performs a read at `if_addr` in the same cycle (`mem_en`=1, `mem_we`=0), with no added latency.
- R3: When `if_req`=1 and `dm_req`=1 in the same cycle, `if_stall`=1 in that cycle and the port carries the data access.
- R4: `if_stall`=0 in every cycle in which fetch and data requests do not collide.
- R5: A store (`dm_req`=1, `dm_we`=1) presents `dm_wdata` on `mem_wdata` in its granted cycle. A later load from that address returns the stored word. A store produces no `dm_rvalid` on the following cycle.
- R6: A load (`dm_req`=1, `dm_we`=0) yields `dm_rvalid`=1 exactly one cycle later, with `dm_rdata` equal to the memory word at `dm_addr`.
- R7: Each granted fetch yields exactly one `if_rvalid`=1 one cycle later, carrying the word at `if_addr`. A denied fetch yields no return. Over a stream with stalls, fetched words arrive in order, with none lost or repeated.
- R8: Whenever `if_rvalid`=0, `if_rdata` equals the bubble word parameter `NOP_WORD` (default 32'h0000_0000).
- R9: With no request pending, `mem_en`=0, and no return valid is raised on the next cycle.
- R10: After reset, `if_rvalid`=0, `dm_rvalid`=0 and `if_stall`=0.
- R11: `if_rvalid` and `dm_rvalid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| if_req | input | 1 | Fetch request from the fetch stage |
| if_addr | input | AW | Fetch word address |
| if_rdata | output | DW | Fetched word, or the bubble word when not valid |
| if_rvalid | output | 1 | Fetched word valid (one cycle after grant) |
| if_stall | output | 1 | Fetch denied this cycle: hold PC, insert bubble |
| dm_req | input | 1 | Load/store request from the data stage |
| dm_we | input | 1 | 1 = store, 0 = load |
| dm_addr | input | AW | Data word address |
| dm_wdata | input | DW | Store data |
| dm_rdata | output | DW | Load data (zero when not valid) |
| dm_rvalid | output | 1 | Load data valid (one cycle after grant) |
| mem_en | output | 1 | Memory port enable |
| mem_we | output | 1 | Memory port write enable |
| mem_addr | output | AW | Memory port address |
| mem_wdata | output | DW | Memory port write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The port drive and `if_stall` are combinational from the requests. They are due in the same cycle, and the bench samples them one time unit after driving the inputs at the falling edge. Read returns pass through one register in the block and one in the memory model. They are due one cycle later, so the bench samples them just after the next falling edge, before any newer return could replace them. The streaming scenario follows a front end that holds its PC under stall. It compares every returned fetch word against an expected counter and checks that the number of returns equals the number of cycles with no data request, which catches lost or doubled fetches.

// File: rtl/umem_pkg.sv
package umem_pkg;
  // Which requester owns the read issued in a cycle
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_FETCH = 2'd1,
    RD_DATA  = 2'd2
  } rd_owner_e;
endpackage

// File: rtl/umem_rst_sync.sv
module umem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/umem_grant.sv
module umem_grant
  import umem_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  input  logic          dm_req,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_addr,
  input  logic [DW-1:0] dm_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          if_stall,
  output rd_owner_e     owner_d
);
  logic fetch_win;

  always_comb begin
    // data stage has fixed priority; fetch wins only an empty cycle
    fetch_win = if_req & ~dm_req;
    if_stall  = if_req & dm_req;

    mem_en    = dm_req | if_req;
    mem_we    = dm_req & dm_we;
    mem_addr  = dm_req ? dm_addr : if_addr;
    mem_wdata = dm_req ? dm_wdata : '0;

    if (dm_req && !dm_we) owner_d = RD_DATA;
    else if (fetch_win)   owner_d = RD_FETCH;
    else                  owner_d = RD_NONE;
  end
endmodule

// File: rtl/umem_return.sv
module umem_return
  import umem_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rd_owner_e     owner_d,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] if_rdata,
  output logic          if_rvalid,
  output logic [DW-1:0] dm_rdata,
  output logic          dm_rvalid
);
  rd_owner_e owner_q;
  rd_owner_e owner_nxt;
  logic      owner_en;

  always_comb begin
    owner_en  = 1'b1;
    owner_nxt = owner_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= RD_NONE;
    else if (owner_en) owner_q <= owner_nxt;
  end

  always_comb begin
    if_rvalid = (owner_q == RD_FETCH);
    dm_rvalid = (owner_q == RD_DATA);
    if_rdata  = if_rvalid ? mem_rdata : NOP_WORD;
    dm_rdata  = dm_rvalid ? mem_rdata : '0;
  end
endmodule

// File: rtl/umem_arbiter.sv
module umem_arbiter
  import umem_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 32,
  parameter logic [DW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  output logic [DW-1:0] if_rdata,
  output logic          if_rvalid,
  output logic          if_stall,
  input  logic          dm_req,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_addr,
  input  logic [DW-1:0] dm_wdata,
  output logic [DW-1:0] dm_rdata,
  output logic          dm_rvalid,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic      rst_sync_n;
  rd_owner_e owner_d;

  umem_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  umem_grant #(.AW(AW), .DW(DW)) u_grant (
    .if_req    (if_req),
    .if_addr   (if_addr),
    .dm_req    (dm_req),
    .dm_we     (dm_we),
    .dm_addr   (dm_addr),
    .dm_wdata  (dm_wdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .if_stall  (if_stall),
    .owner_d   (owner_d)
  );

  umem_return #(.DW(DW), .NOP_WORD(NOP_WORD)) u_ret (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .owner_d   (owner_d),
    .mem_rdata (mem_rdata),
    .if_rdata  (if_rdata),
    .if_rvalid (if_rvalid),
    .dm_rdata  (dm_rdata),
    .dm_rvalid (dm_rvalid)
  );
endmodule

// File: rtl/umem_arbiter_checks.sv
module umem_arbiter_checks #(
  parameter int            AW       = 8,
  parameter int            DW       = 32,
  parameter logic [DW-1:0] NOP_WORD = '0
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          if_req,
  input logic [AW-1:0] if_addr,
  input logic [DW-1:0] if_rdata,
  input logic          if_rvalid,
  input logic          if_stall,
  input logic          dm_req,
  input logic          dm_we,
  input logic [AW-1:0] dm_addr,
  input logic [DW-1:0] dm_wdata,
  input logic          dm_rvalid,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata
);
  assert_data_first_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dm_req |-> (mem_en && mem_addr == dm_addr && mem_we == dm_we));

  assert_fetch_direct_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (if_req && !dm_req) |-> (mem_en && !mem_we && mem_addr == if_addr));

  assert_stall_on_clash_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (if_req && dm_req) |-> if_stall);

  assert_no_spurious_stall_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(if_req && dm_req) |-> !if_stall);

  assert_store_data_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dm_req && dm_we) |-> (mem_wdata == dm_wdata));

  assert_store_no_return_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dm_req && dm_we) |=> !dm_rvalid);

  assert_load_return_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dm_req && !dm_we) |=> dm_rvalid);

  assert_fetch_return_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (if_req && !dm_req) |=> (if_rvalid && if_rdata == mem_rdata));

  assert_denied_no_return_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dm_req |=> !if_rvalid);

  assert_bubble_word_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !if_rvalid |-> (if_rdata == NOP_WORD));

  assert_idle_port_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!if_req && !dm_req) |-> !mem_en);

  assert_single_return_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(if_rvalid && dm_rvalid));
endmodule

bind umem_arbiter umem_arbiter_checks #(
  .AW(AW), .DW(DW), .NOP_WORD(NOP_WORD)
) u_checks (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .if_req     (if_req),
  .if_addr    (if_addr),
  .if_rdata   (if_rdata),
  .if_rvalid  (if_rvalid),
  .if_stall   (if_stall),
  .dm_req     (dm_req),
  .dm_we      (dm_we),
  .dm_addr    (dm_addr),
  .dm_wdata   (dm_wdata),
  .dm_rvalid  (dm_rvalid),
  .mem_en     (mem_en),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rdata  (mem_rdata)
);

// File: tb/umem_arbiter_test.sv
`timescale 1ns/1ps
module umem_arbiter_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [DW-1:0] NOP = 32'h0000_0000;
  localparam logic [DW-1:0] BASE = 32'hA000_0000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          if_req, dm_req, dm_we;
  logic [AW-1:0] if_addr, dm_addr;
  logic [DW-1:0] dm_wdata;
  logic [DW-1:0] if_rdata, dm_rdata;
  logic          if_rvalid, dm_rvalid, if_stall;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // memory model: one port, one-cycle registered read
  logic [DW-1:0] bmem [0:(1<<AW)-1];
  logic [DW-1:0] rd_q;
  initial begin
    for (int i = 0; i < (1<<AW); i++) bmem[i] = BASE + i;
    rd_q = '0;
  end
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        rd_q <= bmem[mem_addr];
    end
  end
  assign mem_rdata = rd_q;

  umem_arbiter #(.AW(AW), .DW(DW), .NOP_WORD(NOP)) uut (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_addr(if_addr), .if_rdata(if_rdata),
    .if_rvalid(if_rvalid), .if_stall(if_stall),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_rdata(dm_rdata), .dm_rvalid(dm_rvalid),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of requests at the falling edge, settle, return
  task automatic step(input logic fr, input logic [AW-1:0] fa, input logic dr,
                      input logic dw, input logic [AW-1:0] da, input logic [DW-1:0] wd);
    @(negedge clk);
    if_req = fr; if_addr = fa; dm_req = dr; dm_we = dw; dm_addr = da; dm_wdata = wd;
    #1;
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    chk(if_rvalid == 1'b0, "R10 if_rvalid", {31'b0, if_rvalid}, 0);
    chk(dm_rvalid == 1'b0, "R10 dm_rvalid", {31'b0, dm_rvalid}, 0);
    chk(if_stall == 1'b0, "R10 if_stall", {31'b0, if_stall}, 0);
    chk(if_rdata == NOP, "R8 bubble after reset", if_rdata, NOP);
  endtask

  task automatic t_fetch_only();
    step(1'b1, 8'd5, 1'b0, 1'b0, '0, '0);
    chk(mem_en && !mem_we && mem_addr == 8'd5, "R2 fetch port", {24'b0, mem_addr}, 5);
    chk(!if_stall, "R4 no stall", {31'b0, if_stall}, 0);
    idle();
    chk(if_rvalid && if_rdata == BASE + 5, "R7 fetch return", if_rdata, BASE + 5);
    chk(!dm_rvalid, "R11 no data return", {31'b0, dm_rvalid}, 0);
  endtask

  task automatic t_load_only();
    step(1'b0, '0, 1'b1, 1'b0, 8'd7, '0);
    chk(mem_en && !mem_we && mem_addr == 8'd7, "R1 load port", {24'b0, mem_addr}, 7);
    idle();
    chk(dm_rvalid && dm_rdata == BASE + 7, "R6 load return", dm_rdata, BASE + 7);
    chk(!if_rvalid && if_rdata == NOP, "R8 bubble on load return", if_rdata, NOP);
  endtask

  task automatic t_store();
    step(1'b0, '0, 1'b1, 1'b1, 8'd9, 32'hDEAD_BEEF);
    chk(mem_en && mem_we && mem_addr == 8'd9, "R1 store port", {24'b0, mem_addr}, 9);
    chk(mem_wdata == 32'hDEAD_BEEF, "R5 store data", mem_wdata, 32'hDEAD_BEEF);
    step(1'b0, '0, 1'b1, 1'b0, 8'd9, '0);
    chk(!dm_rvalid, "R5 store no return", {31'b0, dm_rvalid}, 0);
    idle();
    chk(dm_rvalid && dm_rdata == 32'hDEAD_BEEF, "R5 stored word readback", dm_rdata,
        32'hDEAD_BEEF);
  endtask

  task automatic t_conflict();
    step(1'b1, 8'd3, 1'b1, 1'b0, 8'd12, '0);
    chk(if_stall, "R3 stall on clash", {31'b0, if_stall}, 1);
    chk(mem_addr == 8'd12 && !mem_we, "R3 port to data", {24'b0, mem_addr}, 12);
    // retried fetch, data stage now quiet
    step(1'b1, 8'd3, 1'b0, 1'b0, '0, '0);
    chk(dm_rvalid && dm_rdata == BASE + 12, "R6 load under clash", dm_rdata, BASE + 12);
    chk(!if_rvalid && if_rdata == NOP, "R7 denied fetch no return", if_rdata, NOP);
    chk(!if_stall && mem_addr == 8'd3, "R4 retry granted", {24'b0, mem_addr}, 3);
    idle();
    chk(if_rvalid && if_rdata == BASE + 3, "R7 retried fetch return", if_rdata, BASE + 3);
  endtask

  task automatic t_store_clash();
    step(1'b1, 8'd40, 1'b1, 1'b1, 8'd41, 32'h1234_5678);
    chk(if_stall && mem_we && mem_addr == 8'd41, "R3 store beats fetch", {24'b0, mem_addr}, 41);
    idle();
    chk(!if_rvalid && !dm_rvalid, "R5 no return after store clash",
        {30'b0, if_rvalid, dm_rvalid}, 0);
  endtask

  task automatic t_idle();
    idle();
    chk(!mem_en, "R9 idle port", {31'b0, mem_en}, 0);
    idle();
    chk(!if_rvalid && !dm_rvalid, "R9 no return after idle", {30'b0, if_rvalid, dm_rvalid}, 0);
  endtask

  // front end holding PC under stall; data accesses interleaved
  task automatic t_stream();
    logic [15:0] pattern = 16'b0110_1001_1100_0101;
    logic [AW-1:0] pc = 8'd20;
    logic [AW-1:0] exp_pc = 8'd20;
    int grants = 0;
    int rets = 0;
    int bad = 0;
    int stall_bad = 0;
    int dbad = 0;
    logic prev_load = 1'b0;
    logic [AW-1:0] prev_da = '0;
    for (int k = 0; k < 16; k++) begin
      logic d = pattern[k];
      logic [AW-1:0] da = 8'd100 + AW'(k);
      step(1'b1, pc, d, 1'b0, da, '0);
      if (if_rvalid) begin
        rets++;
        if (if_rdata != BASE + exp_pc) bad++;
        exp_pc++;
      end
      if (prev_load && !(dm_rvalid && dm_rdata == BASE + prev_da)) dbad++;
      if (if_stall != d) stall_bad++;
      if (!d) begin grants++; pc++; end
      prev_load = d; prev_da = da;
    end
    idle();
    if (if_rvalid) begin
      rets++;
      if (if_rdata != BASE + exp_pc) bad++;
      exp_pc++;
    end
    if (prev_load && !(dm_rvalid && dm_rdata == BASE + prev_da)) dbad++;
    chk(rets == grants, "R7 return count equals grants", rets, grants);
    chk(bad == 0, "R7 in-order fetch words", bad, 0);
    chk(exp_pc == pc, "R7 no fetch lost", {24'b0, exp_pc}, {24'b0, pc});
    chk(stall_bad == 0, "R3 stall tracks clashes", stall_bad, 0);
    chk(dbad == 0, "R1 loads never delayed", dbad, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    if_req = 0; dm_req = 0; dm_we = 0; if_addr = '0; dm_addr = '0; dm_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_fetch_only();
    t_load_only();
    t_store();
    t_conflict();
    t_store_clash();
    t_idle();
    t_stream();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule